// File: doc/BRIEF.md
# Power Gating Sequence Controller

This always-on controller moves one switchable logic domain between an active mode and a low-leakage sleep mode. It has one input that asks the domain to sleep and one that asks it to wake. From these it drives the domain clock enable, the isolation controls, the domain reset and the header switch controls. Each of these outputs changes in a fixed order, and every step waits a programmable number of cycles.

Entering sleep runs four steps in order. The domain clock stops first, then isolation clamps the domain outputs, then the domain reset asserts, and last every power switch opens in the same cycle. Waking runs the same steps in reverse. A small trickle switch closes first to precharge the virtual rail. The main switches then close one at a time, lowest index first, to limit in-rush current. After that the domain reset is released, then isolation is dropped, and the clock restarts only once power is fully back. A request that arrives while a sequence is running is held and acted on when that sequence ends. Status outputs report whether the domain is asleep and whether a sequence is in progress.

Top module: `pgate_seq`

## Requirements
- R1: After the controller's synchronous reset the domain is active: `dom_clk_en`=1, `iso_hi`=0, `iso_lo_n`=1, `dom_rst_n`=1, `trickle_off`=0, `main_off`=0, `asleep`=0, `busy`=0.
- R2: A `sleep_req` sampled at edge E in the active state drives `dom_clk_en` low at E. `iso_hi` rises at E+t_clk_stop+1. `dom_rst_n` falls t_iso_set+1 edges after that. `trickle_off` and every `main_off` bit go high together one edge after the reset falls.
- R3: A `wake_req` sampled at edge F in the asleep state drives `trickle_off` low at F while every `main_off` bit stays high until F+t_trickle+1. A switch control at 1 means the switch is open and at 0 means it conducts.
- R4: On power-up the main switches close one per step in ascending bit order, starting with bit 0 at F+t_trickle+1. Consecutive closures are t_gap+1 edges apart, and two `main_off` bits never fall at the same edge.
- R5: `dom_rst_n` rises t_gap+1 edges after the last main switch closes. `iso_hi` falls t_rst_rel+1 edges later, and `dom_clk_en` rises one edge after that. The clock is never enabled while any switch is open, the reset is asserted or isolation is on.
- R6: `iso_lo_n` is always the complement of `iso_hi`.
- R7: `asleep` rises one edge after the switches open. It falls at the same edge at which `dom_clk_en` rises.
- R8: `busy` is 1 from the first step of a sequence through its last step, and 0 only in the settled active or asleep state.
- R9: A request for the opposite state that arrives during a running sequence is held. The new sequence starts one edge after the current one settles.
- R10: A request matching the current settled state has no effect. When both requests arrive in the same cycle in a settled state, the one that changes the state wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| sleep_req | input | 1 | Request to enter sleep |
| wake_req | input | 1 | Request to return to active mode |
| t_clk_stop | input | CW | Extra cycles after the clock stops, before isolation |
| t_iso_set | input | CW | Extra cycles after isolation, before domain reset |
| t_trickle | input | CW | Extra cycles of trickle charge before the first main switch |
| t_gap | input | CW | Extra cycles between main switch closures |
| t_rst_rel | input | CW | Extra cycles after reset release, before isolation drops |
| dom_clk_en | output | 1 | Domain clock enable |
| iso_hi | output | 1 | Isolation, active high (clamp-high cells) |
| iso_lo_n | output | 1 | Isolation, active low (clamp-low cells) |
| dom_rst_n | output | 1 | Domain reset, active low |
| trickle_off | output | 1 | Trickle switch control, 1 = open |
| main_off | output | N_MAIN | Main switch controls, 1 = open, bit 0 closes first |
| asleep | output | 1 | Domain is powered down |
| busy | output | 1 | A sequence is in progress |

## Verification
Two functions can fall in the same cycle. A request can be taken in while a sequence is finishing, and a sleep and a wake request can collide. The bench raises a request in the middle of a power-up and checks that the next power-down starts exactly one edge after the clock comes back. It then raises both requests together while powering down, and checks that a wake is held and that trickle charging starts one edge after the asleep state is reached. In each settled state it also raises both requests at once, and checks that only the one that changes the state takes effect.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [3:0] {
    ST_ON     = 4'd0,
    ST_D_CLK  = 4'd1,
    ST_D_ISO  = 4'd2,
    ST_D_RST  = 4'd3,
    ST_D_PWR  = 4'd4,
    ST_OFF    = 4'd5,
    ST_U_TRK  = 4'd6,
    ST_U_MAIN = 4'd7,
    ST_U_RST  = 4'd8,
    ST_U_ISO  = 4'd9
  } pg_state_e;
endpackage

// File: rtl/pgc_wait_timer.sv
module pgc_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

  AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1))); // R2
endmodule

// File: rtl/pgc_stagger.sv
module pgc_stagger #(
  parameter int N_MAIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  output logic [N_MAIN-1:0] sw_off,
  output logic              all_on
);
  logic [N_MAIN-1:0] sw_on;

  generate
    if (N_MAIN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)        sw_on <= 1'b1;
        else if (clear) sw_on <= 1'b0;
        else if (step)  sw_on <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)        sw_on <= '1;
        else if (clear) sw_on <= '0;
        else if (step)  sw_on <= {sw_on[N_MAIN-2:0], 1'b1};
      end
    end
  endgenerate

  assign sw_off = ~sw_on;
  assign all_on = &sw_on;

  AST_ONE_SWITCH_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ($countones(sw_off ^ $past(sw_off)) <= 1)); // R4
  AST_CLOSE_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(sw_off)); // R4
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
  import pgc_pkg::*;
#(
  parameter int N_MAIN = 4,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic [CW-1:0]     t_clk_stop,
  input  logic [CW-1:0]     t_iso_set,
  input  logic [CW-1:0]     t_trickle,
  input  logic [CW-1:0]     t_gap,
  input  logic [CW-1:0]     t_rst_rel,
  output logic              dom_clk_en,
  output logic              iso_hi,
  output logic              iso_lo_n,
  output logic              dom_rst_n,
  output logic              trickle_off,
  output logic [N_MAIN-1:0] main_off,
  output logic              asleep,
  output logic              busy
);
  pg_state_e     st, st_n;
  logic          pend;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          sw_clear, sw_step, sw_all_on;

  pgc_wait_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  pgc_stagger #(.N_MAIN(N_MAIN)) u_stag (
    .clk(clk), .rst(rst), .clear(sw_clear), .step(sw_step),
    .sw_off(main_off), .all_on(sw_all_on)
  );

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sw_clear = 1'b0;
    sw_step  = 1'b0;
    case (st)
      ST_ON:     if (sleep_req || pend) begin
                   st_n = ST_D_CLK; tmr_load = 1'b1; tmr_val = t_clk_stop;
                 end
      ST_D_CLK:  if (tmr_done) begin
                   st_n = ST_D_ISO; tmr_load = 1'b1; tmr_val = t_iso_set;
                 end
      ST_D_ISO:  if (tmr_done) begin
                   st_n = ST_D_RST; tmr_load = 1'b1;
                 end
      ST_D_RST:  if (tmr_done) begin
                   st_n = ST_D_PWR; tmr_load = 1'b1; sw_clear = 1'b1;
                 end
      ST_D_PWR:  if (tmr_done) st_n = ST_OFF;
      ST_OFF:    if (wake_req || pend) begin
                   st_n = ST_U_TRK; tmr_load = 1'b1; tmr_val = t_trickle;
                 end
      ST_U_TRK:  if (tmr_done) begin
                   st_n = ST_U_MAIN; tmr_load = 1'b1; tmr_val = t_gap; sw_step = 1'b1;
                 end
      ST_U_MAIN: if (tmr_done) begin
                   tmr_load = 1'b1;
                   if (!sw_all_on) begin
                     sw_step = 1'b1; tmr_val = t_gap;
                   end else begin
                     st_n = ST_U_RST; tmr_val = t_rst_rel;
                   end
                 end
      ST_U_RST:  if (tmr_done) begin
                   st_n = ST_U_ISO; tmr_load = 1'b1;
                 end
      ST_U_ISO:  if (tmr_done) st_n = ST_ON;
      default:   st_n = ST_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_ON;
      pend <= 1'b0;
    end else begin
      st <= st_n;
      case (st)
        ST_ON, ST_OFF:                         pend <= 1'b0;
        ST_D_CLK, ST_D_ISO, ST_D_RST, ST_D_PWR: if (wake_req)  pend <= 1'b1;
        default:                               if (sleep_req) pend <= 1'b1;
      endcase
    end
  end

  // Outputs are registered from the next state, so they change with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      dom_clk_en  <= 1'b1;
      iso_hi      <= 1'b0;
      iso_lo_n    <= 1'b1;
      dom_rst_n   <= 1'b1;
      trickle_off <= 1'b0;
      asleep      <= 1'b0;
      busy        <= 1'b0;
    end else begin
      dom_clk_en  <= (st_n == ST_ON);
      iso_hi      <= !(st_n inside {ST_ON, ST_D_CLK, ST_U_ISO});
      iso_lo_n    <=  (st_n inside {ST_ON, ST_D_CLK, ST_U_ISO});
      dom_rst_n   <= !(st_n inside {ST_D_RST, ST_D_PWR, ST_OFF, ST_U_TRK, ST_U_MAIN});
      trickle_off <=  (st_n inside {ST_D_PWR, ST_OFF});
      asleep      <=  (st_n inside {ST_OFF, ST_U_TRK, ST_U_MAIN, ST_U_RST, ST_U_ISO});
      busy        <= !(st_n inside {ST_ON, ST_OFF});
    end
  end

  AST_ISO_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    iso_lo_n == !iso_hi); // R6
  AST_CLK_ONLY_WHEN_POWERED: assert property (@(posedge clk) disable iff (rst)
    dom_clk_en |-> (main_off == '0 && !trickle_off && dom_rst_n && !iso_hi)); // R5
  AST_OFF_AFTER_ISO_AND_RST: assert property (@(posedge clk) disable iff (rst)
    $rose(trickle_off) |-> ($past(iso_hi) && !$past(dom_rst_n))); // R2
  AST_ASLEEP_MEANS_OPEN: assert property (@(posedge clk) disable iff (rst)
    (asleep && !busy) |-> (trickle_off && (&main_off))); // R7
  AST_IDLE_IS_SETTLED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dom_clk_en != asleep)); // R8
  AST_TRICKLE_LEADS_MAIN: assert property (@(posedge clk) disable iff (rst)
    ($fell(main_off[0]) && busy) |-> $past(!trickle_off)); // R3
endmodule

// File: tb/pgate_seq_bench.sv
module pgate_seq_bench;
  localparam int PERIOD = 10;
  localparam int N_MAIN = 4;
  localparam int CW     = 8;
  localparam int NCFG   = 3;
  // columns: clock stop, iso set, trickle, gap, reset release
  localparam int CFG [NCFG][5] = '{'{1, 2, 3, 1, 2},
                                   '{0, 0, 0, 0, 0},
                                   '{4, 1, 2, 3, 0}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic [CW-1:0] t_clk_stop, t_iso_set, t_trickle, t_gap, t_rst_rel;
  logic dom_clk_en, iso_hi, iso_lo_n, dom_rst_n, trickle_off, asleep, busy;
  logic [N_MAIN-1:0] main_off;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  pgate_seq #(.N_MAIN(N_MAIN), .CW(CW)) u_pgate_seq (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .t_clk_stop(t_clk_stop), .t_iso_set(t_iso_set), .t_trickle(t_trickle),
    .t_gap(t_gap), .t_rst_rel(t_rst_rel),
    .dom_clk_en(dom_clk_en), .iso_hi(iso_hi), .iso_lo_n(iso_lo_n),
    .dom_rst_n(dom_rst_n), .trickle_off(trickle_off), .main_off(main_off),
    .asleep(asleep), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_cfg(input int r);
    t_clk_stop = CW'(CFG[r][0]);
    t_iso_set  = CW'(CFG[r][1]);
    t_trickle  = CW'(CFG[r][2]);
    t_gap      = CW'(CFG[r][3]);
    t_rst_rel  = CW'(CFG[r][4]);
  endtask

  task automatic run_down(input int r);
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R2 clock stops first", 32'(dom_clk_en), 0);
    chk("R8 busy on start", 32'(busy), 1);
    ticks(CFG[r][0]);
    chk("R2 iso not early", 32'(iso_hi), 0);
    tick();
    chk("R2 iso asserted", 32'(iso_hi), 1);
    chk("R6 iso pair", 32'(iso_lo_n), 0);
    ticks(CFG[r][1]);
    chk("R2 reset not early", 32'(dom_rst_n), 1);
    tick();
    chk("R2 reset asserted", 32'(dom_rst_n), 0);
    chk("R2 switches still on", 32'({trickle_off, main_off}), 0);
    tick();
    chk("R2 all switches off", 32'({trickle_off, main_off}), 32'((1 << (N_MAIN + 1)) - 1));
    chk("R7 asleep lags switches", 32'(asleep), 0);
    tick();
    chk("R7 asleep", 32'(asleep), 1);
    chk("R8 busy cleared", 32'(busy), 0);
  endtask

  task automatic run_up(input int r);
    wake_req = 1'b1; tick(); wake_req = 1'b0;
    chk("R3 trickle first", 32'(trickle_off), 0);
    chk("R3 mains held", 32'(main_off), 32'({N_MAIN{1'b1}}));
    ticks(CFG[r][2]);
    chk("R3 mains wait trickle", 32'(main_off), 32'({N_MAIN{1'b1}}));
    tick();
    chk("R4 first main", 32'(main_off), 32'(N_MAIN'({N_MAIN{1'b1}} << 1)));
    for (int k = 1; k < N_MAIN; k++) begin
      ticks(CFG[r][3]);
      chk("R4 gap held", 32'(main_off), 32'(N_MAIN'({N_MAIN{1'b1}} << k)));
      tick();
      chk("R4 next main", 32'(main_off), 32'(N_MAIN'({N_MAIN{1'b1}} << (k + 1))));
    end
    ticks(CFG[r][3]);
    chk("R5 reset held", 32'(dom_rst_n), 0);
    tick();
    chk("R5 reset released", 32'(dom_rst_n), 1);
    ticks(CFG[r][4]);
    chk("R5 iso held", 32'(iso_hi), 1);
    tick();
    chk("R5 iso released", 32'(iso_hi), 0);
    chk("R6 iso pair", 32'(iso_lo_n), 1);
    chk("R5 clock after iso", 32'(dom_clk_en), 0);
    chk("R7 asleep until clock", 32'(asleep), 1);
    tick();
    chk("R5 clock on", 32'(dom_clk_en), 1);
    chk("R7 active with clock", 32'(asleep), 0);
    chk("R8 busy cleared", 32'(busy), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    set_cfg(0);
    ticks(3);
    rst = 1'b0;
    chk("R1 clk_en", 32'(dom_clk_en), 1);
    chk("R1 iso", 32'({iso_hi, iso_lo_n}), 1);
    chk("R1 rst_n", 32'(dom_rst_n), 1);
    chk("R1 switches", 32'({trickle_off, main_off}), 0);
    chk("R1 status", 32'({asleep, busy}), 0);

    wake_req = 1'b1; tick(); wake_req = 1'b0;
    chk("R10 wake ignored when active", 32'({busy, dom_clk_en}), 1);
    ticks(2);
    chk("R10 still idle", 32'({busy, dom_clk_en}), 1);

    for (int r = 0; r < NCFG; r++) begin
      set_cfg(r);
      run_down(r);
      run_up(r);
    end

    set_cfg(0);
    sleep_req = 1'b1; wake_req = 1'b1; tick(); sleep_req = 1'b0; wake_req = 1'b0;
    chk("R10 sleep wins when active", 32'(dom_clk_en), 0);
    while (!(asleep && !busy)) tick();

    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R10 sleep ignored when asleep", 32'({busy, trickle_off}), 1);
    tick();
    chk("R10 still asleep", 32'({busy, trickle_off}), 1);

    sleep_req = 1'b1; wake_req = 1'b1; tick(); sleep_req = 1'b0; wake_req = 1'b0;
    chk("R10 wake wins when asleep", 32'(trickle_off), 0);
    tick();
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R9 sleep held, power-up continues", 32'(busy), 1);
    while (!dom_clk_en) tick();
    chk("R9 one settled cycle", 32'(busy), 0);
    tick();
    chk("R9 held sleep starts", 32'({dom_clk_en, busy}), 1);
    tick();
    sleep_req = 1'b1; wake_req = 1'b1; tick(); sleep_req = 1'b0; wake_req = 1'b0;
    while (!asleep) tick();
    chk("R9 reached asleep", 32'({busy, trickle_off}), 1);
    tick();
    chk("R9 held wake starts", 32'({busy, trickle_off}), 32'b10);
    while (!dom_clk_en) tick();
    chk("R9 back active", 32'({asleep, busy}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule